// File: doc/BRIEF.md
# Clock Mode Request Arbiter

This block decides which operating mode a small clock generator is really in. Software issues a write carrying a 2-bit mode request and a reference-select bit. The block keeps the request. It also reports a separate 2-bit status that shows the mode actually reached. The status catches up with the request only after a fixed settling delay, and only when the readiness flags from the oscillator and the frequency-locked loop allow the requested mode. If they do not allow it, the status drops back to the self-clocked mode and waits there.

The reference-select bit can be written once. The first request write after reset captures it, and every later write leaves it alone. It drives the external oscillator enable, so if the first write leaves it clear, no external-reference mode can be reached until the next reset. A 2-bit select output tells the downstream clock multiplexer whether the output clock comes from the divided DCO clock or from the divided external reference.

Mode codes, used by both the request and the status: 00 self-clocked, 01 loop engaged on the internal reference, 10 loop bypassed on the external reference, 11 loop engaged on the external reference.

Top module: `clk_mode_arbiter`

## Requirements
- R1: While reset is asserted and right after it, reqMode and statMode read 00, oscEnable reads 0 and outSel reads 00.
- R2: A clock edge with wrEn high loads wrMode into reqMode, and reqMode shows it after that edge.
- R3: After a write edge, statMode holds its value for the next three edges and is re-evaluated on the fourth. A further write within that window restarts the four-edge delay. The only exception is the forced fallback of R9.
- R4: Code 00 is always reachable: once evaluated, a request for 00 puts 00 on statMode.
- R5: Code 01 is reached only if dcoStable is 1 at the evaluating edge.
- R6: Code 10 is reached only if extStable is 1 and oscEnable is 1 at the evaluating edge.
- R7: Code 11 is reached only if extStable, dcoStable and oscEnable are all 1 at the evaluating edge.
- R8: When the delay has run out and the requested mode is not reachable, statMode becomes 00. The check is repeated on every edge, and statMode moves to the request on the first edge at which its conditions hold.
- R9: An edge at which lossOfClock is 1 and dcoStable is 0 sets statMode to 00. This overrides both the delay and the request.
- R10: The first write after reset copies wrRefSel into oscEnable. Later writes leave oscEnable unchanged until the next reset.
- R11: outSel is 01 (divided external reference) when statMode is 10. For every other status it is 00 (divided DCO clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Request write strobe |
| wrMode | input | 2 | Requested mode code for the write |
| wrRefSel | input | 1 | Reference-select value, kept only on the first write |
| extStable | input | 1 | External reference is stable |
| dcoStable | input | 1 | DCO is stable |
| lossOfClock | input | 1 | Loss-of-clock indication |
| reqMode | output | 2 | Stored requested mode |
| statMode | output | 2 | Mode actually reached |
| oscEnable | output | 1 | Locked reference select, which enables the external oscillator |
| outSel | output | 2 | Output clock source select: 00 DCO/R, 01 external/R |

## Verification
Two situations are hard to reach from the ports. The first is a status that stays away from the request for good because the reference select was locked at 0. The second is a second write landing inside the settling window. The bench runs an exhaustive sweep of every request code against every flag combination twice, once after a first write that locks the select to 1 and once after a first write that locks it to 0. A long pseudo-random phase then fires writes at random gaps, so rewrites land mid-window. In the same phase, flags change while the status is waiting, and occasional resets reopen the write-once lock.

// File: rtl/cmr_pkg.sv
`timescale 1ns/1ps
package cmr_pkg;

  typedef enum logic [1:0] {
    MODE_SCM     = 2'b00,
    MODE_FLL_INT = 2'b01,
    MODE_BYP_EXT = 2'b10,
    MODE_FLL_EXT = 2'b11
  } clkMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;   // capture request (and first reference select)
    logic holdStat;  // settling window open: keep status
    logic forceScm;  // loss of clock with unstable DCO
  } ctrlStb_t;

  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_DCO = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_EXT = SEL_W'(1);

endpackage

// File: rtl/cmr_ctrl.sv
`timescale 1ns/1ps
module cmr_ctrl
  import cmr_pkg::*;
#(
  parameter int LAG_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic     dcoStable,
  input  logic     lossOfClock,
  output ctrlStb_t stb
);

  localparam int CNT_W = (LAG_CYCLES > 2) ? $clog2(LAG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LAG_CYCLES - 1);

  logic [CNT_W-1:0] lagCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lagCnt <= '0;
    end else if (wrEn) begin
      lagCnt <= LOAD_VAL;
    end else if (lagCnt != '0) begin
      lagCnt <= lagCnt - CNT_W'(1);
    end
  end

  always_comb begin
    stb.takeReq  = wrEn;
    stb.holdStat = wrEn || (lagCnt != '0);
    stb.forceScm = lossOfClock && !dcoStable;
  end

  // R3: every write reopens the full window
  a_r3_window_reload: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (lagCnt == LOAD_VAL));

  // R3: the window shrinks by one per edge without writes
  a_r3_window_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && lagCnt != '0) |=> (lagCnt == $past(lagCnt) - CNT_W'(1)));

endmodule

// File: rtl/cmr_dpath.sv
`timescale 1ns/1ps
module cmr_dpath
  import cmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [1:0]       wrMode,
  input  logic             wrRefSel,
  input  logic             extStable,
  input  logic             dcoStable,
  output clkMode_e         reqMode,
  output clkMode_e         statMode,
  output logic             oscEnable,
  output logic [SEL_W-1:0] outSel
);

  logic refSel;
  logic refLocked;
  logic reachable;

  // request register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqMode <= MODE_SCM;
    end else if (stb.takeReq) begin
      reqMode <= clkMode_e'(wrMode);
    end
  end

  // write-once reference select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSel    <= 1'b0;
      refLocked <= 1'b0;
    end else if (stb.takeReq && !refLocked) begin
      refSel    <= wrRefSel;
      refLocked <= 1'b1;
    end
  end

  always_comb begin
    case (reqMode)
      MODE_SCM:     reachable = 1'b1;
      MODE_FLL_INT: reachable = dcoStable;
      MODE_BYP_EXT: reachable = extStable && refSel;
      MODE_FLL_EXT: reachable = extStable && dcoStable && refSel;
      default:      reachable = 1'b0;
    endcase
  end

  // reached-mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statMode <= MODE_SCM;
    end else if (stb.forceScm) begin
      statMode <= MODE_SCM;
    end else if (!stb.holdStat) begin
      statMode <= reachable ? reqMode : MODE_SCM;
    end
  end

  assign oscEnable = refSel;
  assign outSel    = (statMode == MODE_BYP_EXT) ? SEL_EXT : SEL_DCO;

  // R10: once locked, the select never moves before the next reset
  a_r10_ref_frozen: assert property (@(posedge clk) disable iff (!rstN)
    refLocked |=> ($stable(refSel) && refLocked));

endmodule

// File: rtl/clk_mode_arbiter.sv
`timescale 1ns/1ps
module clk_mode_arbiter
  import cmr_pkg::*;
#(
  parameter int LAG_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrMode,
  input  logic       wrRefSel,
  input  logic       extStable,
  input  logic       dcoStable,
  input  logic       lossOfClock,
  output logic [1:0] reqMode,
  output logic [1:0] statMode,
  output logic       oscEnable,
  output logic [1:0] outSel
);

  ctrlStb_t stb;
  clkMode_e reqModeE;
  clkMode_e statModeE;
  logic [SEL_W-1:0] outSelInt;

  cmr_ctrl #(.LAG_CYCLES(LAG_CYCLES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .dcoStable  (dcoStable),
    .lossOfClock(lossOfClock),
    .stb        (stb)
  );

  cmr_dpath dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrMode    (wrMode),
    .wrRefSel  (wrRefSel),
    .extStable (extStable),
    .dcoStable (dcoStable),
    .reqMode   (reqModeE),
    .statMode  (statModeE),
    .oscEnable (oscEnable),
    .outSel    (outSelInt)
  );

  assign reqMode  = reqModeE;
  assign statMode = statModeE;
  assign outSel   = 2'(outSelInt);

  a_r2_request_capture: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (reqMode == $past(wrMode)));

  a_r3_no_early_move: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ($stable(statMode) || statMode == 2'b00));

  a_r5_int_needs_dco: assert property (@(posedge clk) disable iff (!rstN)
    (statMode == 2'b01 && $past(statMode) != 2'b01) |-> $past(dcoStable));

  a_r6_bypass_needs_ext: assert property (@(posedge clk) disable iff (!rstN)
    (statMode == 2'b10 && $past(statMode) != 2'b10) |-> $past(extStable && oscEnable));

  a_r7_ext_fll_needs_all: assert property (@(posedge clk) disable iff (!rstN)
    (statMode == 2'b11 && $past(statMode) != 2'b11)
      |-> $past(extStable && dcoStable && oscEnable));

  a_r9_loss_forces_scm: assert property (@(posedge clk) disable iff (!rstN)
    (lossOfClock && !dcoStable) |=> (statMode == 2'b00));

endmodule

// File: tb/clk_mode_arbiter_tb_top.sv
`timescale 1ns/1ps
module clk_mode_arbiter_tb_top;

  localparam int LAG = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrMode = 2'b00;
  logic       wrRefSel = 1'b0;
  logic       extStable = 1'b0;
  logic       dcoStable = 1'b0;
  logic       lossOfClock = 1'b0;
  logic [1:0] reqMode;
  logic [1:0] statMode;
  logic       oscEnable;
  logic [1:0] outSel;

  always #10 clk = ~clk;  // 50 MHz

  clk_mode_arbiter #(.LAG_CYCLES(LAG)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMode(wrMode), .wrRefSel(wrRefSel),
    .extStable(extStable), .dcoStable(dcoStable), .lossOfClock(lossOfClock),
    .reqMode(reqMode), .statMode(statMode), .oscEnable(oscEnable), .outSel(outSel)
  );

  int nChecks = 0;
  int nFails = 0;

  // spec model
  int mReq = 0, mStat = 0, mCnt = 0;
  bit mLock = 0, mRef = 0;
  string statTag = "R1";
  bit inReset = 1;
  logic [31:0] rng = 32'h1234_5678;

  function automatic bit reachOk(int m, bit ext, bit dco, bit rf);
    case (m)
      0: return 1'b1;
      1: return dco;
      2: return ext && rf;
      default: return ext && dco && rf;
    endcase
  endfunction

  task automatic modelStep();
    bit force_;
    bit hold;
    if (!rstN) begin
      mReq = 0; mStat = 0; mCnt = 0; mLock = 0; mRef = 0;
      inReset = 1; statTag = "R1";
      return;
    end
    inReset = 0;
    force_ = lossOfClock && !dcoStable;
    hold = wrEn || (mCnt != 0);
    if (force_) statTag = "R9";
    else if (hold) statTag = "R3";
    else if (mReq == 0) statTag = "R4";
    else if (!reachOk(mReq, extStable, dcoStable, mRef)) statTag = "R8";
    else if (mReq == 1) statTag = "R5";
    else if (mReq == 2) statTag = "R6";
    else statTag = "R7";
    if (force_) mStat = 0;
    else if (!hold) mStat = reachOk(mReq, extStable, dcoStable, mRef) ? mReq : 0;
    if (wrEn) begin
      mReq = int'(wrMode);
      if (!mLock) begin mRef = wrRefSel; mLock = 1; end
      mCnt = LAG - 1;
    end else if (mCnt != 0) begin
      mCnt = mCnt - 1;
    end
  endtask

  task automatic chk(int act, int exp, string tag, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk(int'(reqMode), mReq, inReset ? "R1" : "R2", "reqMode");
    chk(int'(statMode), mStat, statTag, "statMode");
    chk(int'(oscEnable), int'(mRef), inReset ? "R1" : "R10", "oscEnable");
    chk(int'(outSel), (mStat == 2) ? 1 : 0, inReset ? "R1" : "R11", "outSel");
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll();
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();  // R1: still all zero after release
  endtask

  task automatic writeReq(int m, bit rf);
    wrEn = 1'b1; wrMode = 2'(m); wrRefSel = rf;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic sweep();
    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 8; f++) begin
        extStable = f[0]; dcoStable = f[1]; lossOfClock = f[2];
        writeReq(m, ~mRef);  // R10: opposite select must be ignored
        for (int k = 0; k < LAG + 2; k++) tick();
      end
    end
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // phase A: lock select to 1
    writeReq(0, 1'b1);
    for (int k = 0; k < LAG + 1; k++) tick();
    sweep();
    // phase B: lock select to 0, external modes unreachable (R6, R7)
    doReset();
    writeReq(2, 1'b0);
    extStable = 1'b1; dcoStable = 1'b1; lossOfClock = 1'b0;
    for (int k = 0; k < LAG + 1; k++) tick();
    sweep();
    // phase C: pseudo-random writes, mid-window rewrites, flag changes
    doReset();
    for (int k = 0; k < 6000; k++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      wrEn = (rng[2:0] == 3'd0);
      wrMode = rng[4:3];
      wrRefSel = rng[5];
      if (rng[17:15] == 3'd0) begin
        extStable = (rng[8:6] != 3'd0);
        dcoStable = (rng[11:9] != 3'd0);
        lossOfClock = (rng[14:12] == 3'd0);
      end
      rstN = (rng[31:22] != 10'd0);
      tick();
    end
    rstN = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule